// File: doc/BRIEF.md
# Packed Unsigned Lane Maximum Unit

This block is a single-cycle registered SIMD datapath. It takes two operand vectors made of equal-width lanes. For each lane it returns the larger value, and it treats every lane as an unsigned integer. It serves an execution pipeline that has already decoded the operation, fetched the operands and read the previous value of the destination register. The result goes back to the register file, together with a write-enable and an undefined-operation fault flag.

A 2-bit form code selects how the upper half of the result is written back:
- **Narrow form (`00`):** the destination is also the first source. Only the lower half of the lanes is computed, and the upper half keeps the previous destination value.
- **Narrow-clearing form (`01`):** the lower half is computed and the upper half is cleared.
- **Wide form (`10`):** every lane is computed. This form is allowed only while the wide-vector enable is high.
- **Illegal (`11`):** this code raises the fault. The wide form with the enable low also raises the fault. A faulting operation writes nothing.

Each accepted operation produces its outputs one clock edge later, marked by `valid_out`.

Top module: `pkmax_unit`

## Requirements
- R1: For every computed lane i, bits [i*LANE_W +: LANE_W] of `result` hold the unsigned maximum of the matching lanes of `src_a` and `src_b`. When the lane of `src_a` is strictly greater, that value is chosen. Otherwise the lane of `src_b` is chosen. For a non-faulting operation, the lower LANES/2 lanes are always computed.
- R2: With `form` = 00, result bits [VEC_W-1:VEC_W/2] equal `dst_prev_hi`, and `wr_en` is 1.
- R3: With `form` = 01, result bits [VEC_W-1:VEC_W/2] are zero, and `wr_en` is 1.
- R4: With `form` = 10 and `wide_en` = 1, all LANES lanes follow R1, and `wr_en` is 1.
- R5: With `form` = 11, `fault` is 1, `wr_en` is 0 and `result` is all zero.
- R6: With `form` = 10 and `wide_en` = 0, `fault` is 1, `wr_en` is 0 and `result` is all zero.
- R7: An operation presented with `valid_in` = 1 at a rising edge shows its `result`, `wr_en` and `fault` after that edge, with `valid_out` = 1. After an edge where `valid_in` = 0, `valid_out`, `wr_en` and `fault` are 0.
- R8: When `rst` is high at a rising edge, `valid_out`, `wr_en`, `fault` and `result` are cleared after that edge.
- R9: After an edge where `valid_in` = 0, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operation present this cycle |
| form | input | 2 | Form code: 00 narrow, 01 narrow-clearing, 10 wide, 11 illegal |
| wide_en | input | 1 | Permits the wide form |
| src_a | input | LANE_W*LANES | First operand vector |
| src_b | input | LANE_W*LANES | Second operand vector |
| dst_prev_hi | input | LANE_W*LANES/2 | Upper half of the previous destination value |
| valid_out | output | 1 | Registered outputs belong to an operation |
| result | output | LANE_W*LANES | Registered result vector |
| wr_en | output | 1 | Write the result back |
| fault | output | 1 | Undefined-operation fault |

## Verification
The bench builds the unit with LANE_W = 4 and LANES = 4, which gives four 4-bit lanes. At this size every pair of lane values (16 × 16) can be applied to every lane, for every form code and both settings of the wide enable. This exhaustive sweep contains the all-zero and all-ones lanes, equal lanes, and the top-bit case 8 against 7. In that case a signed compare would pick the other lane, so the sweep shows that the compare is unsigned. Because the upper-half path is reached through the same two lanes of the half split as at full width, each write-back form and each fault path is exercised completely.

// File: rtl/pkmax_pkg.sv
`timescale 1ns/1ps
package pkmax_pkg;
  typedef enum logic [1:0] {
    FORM_NARROW = 2'b00,
    FORM_CLEAR  = 2'b01,
    FORM_WIDE   = 2'b10,
    FORM_BAD    = 2'b11
  } form_e;

  typedef enum logic [1:0] {
    UP_KEEP = 2'b00,
    UP_ZERO = 2'b01,
    UP_CALC = 2'b10
  } upper_e;
endpackage

// File: rtl/lane_max_array.sv
`timescale 1ns/1ps
module lane_max_array #(
  parameter int LANE_W = 32,
  parameter int LANES  = 8
) (
  input  logic [LANE_W*LANES-1:0] op_a,
  input  logic [LANE_W*LANES-1:0] op_b,
  output logic [LANE_W*LANES-1:0] op_max
);
  function automatic logic [LANE_W-1:0] umax(input logic [LANE_W-1:0] a,
                                             input logic [LANE_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign op_max[i*LANE_W +: LANE_W] = umax(op_a[i*LANE_W +: LANE_W],
                                             op_b[i*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/form_decode.sv
`timescale 1ns/1ps
module form_decode
  import pkmax_pkg::*;
(
  input  logic [1:0] form_code,
  input  logic       wide_ok,
  output logic       bad_code,
  output logic       wide_denied,
  output upper_e     upper_mode
);
  always_comb begin
    bad_code    = 1'b0;
    wide_denied = 1'b0;
    upper_mode  = UP_ZERO;
    case (form_e'(form_code))
      FORM_NARROW: upper_mode = UP_KEEP;
      FORM_CLEAR:  upper_mode = UP_ZERO;
      FORM_WIDE: begin
        if (wide_ok) upper_mode = UP_CALC;
        else         wide_denied = 1'b1;
      end
      default:     bad_code = 1'b1;
    endcase
  end
endmodule

// File: rtl/pkmax_unit.sv
`timescale 1ns/1ps
module pkmax_unit
  import pkmax_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          valid_in,
  input  logic [1:0]                    form,
  input  logic                          wide_en,
  input  logic [LANE_W*LANES-1:0]       src_a,
  input  logic [LANE_W*LANES-1:0]       src_b,
  input  logic [LANE_W*LANES/2-1:0]     dst_prev_hi,
  output logic                          valid_out,
  output logic [LANE_W*LANES-1:0]       result,
  output logic                          wr_en,
  output logic                          fault
);
  localparam int VEC_W  = LANE_W * LANES;
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0]  max_all;
  logic [HALF_W-1:0] upper_next;
  logic [VEC_W-1:0]  result_next;
  logic              ev_bad_code;
  logic              ev_wide_denied;
  logic              ev_fault;
  upper_e            up_mode;

  lane_max_array #(.LANE_W(LANE_W), .LANES(LANES)) u_lanes (
    .op_a   (src_a),
    .op_b   (src_b),
    .op_max (max_all)
  );

  form_decode u_dec (
    .form_code   (form),
    .wide_ok     (wide_en),
    .bad_code    (ev_bad_code),
    .wide_denied (ev_wide_denied),
    .upper_mode  (up_mode)
  );

  always_comb begin
    ev_fault = ev_bad_code | ev_wide_denied;
    case (up_mode)
      UP_KEEP: upper_next = dst_prev_hi;
      UP_CALC: upper_next = max_all[VEC_W-1:HALF_W];
      default: upper_next = '0;
    endcase
    result_next = ev_fault ? '0 : {upper_next, max_all[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      wr_en     <= 1'b0;
      fault     <= 1'b0;
      result    <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result <= result_next;
        fault  <= ev_fault;
        wr_en  <= ~ev_fault;
      end else begin
        fault  <= 1'b0;
        wr_en  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkmax_chk.sv
`timescale 1ns/1ps
module pkmax_chk #(
  parameter int LANE_W = 32,
  parameter int LANES  = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      valid_in,
  input logic [1:0]                form,
  input logic                      wide_en,
  input logic [LANE_W*LANES-1:0]   src_a,
  input logic [LANE_W*LANES-1:0]   src_b,
  input logic [LANE_W*LANES/2-1:0] dst_prev_hi,
  input logic                      valid_out,
  input logic [LANE_W*LANES-1:0]   result,
  input logic                      wr_en,
  input logic                      fault,
  input logic                      ev_bad_code,
  input logic                      ev_wide_denied
);
  localparam int VEC_W  = LANE_W * LANES;
  localparam int HALF_W = VEC_W / 2;

  p_lane0_max_r1: assert property (@(posedge clk) disable iff (rst)
    (valid_in && form != 2'b11 && !(form == 2'b10 && !wide_en)) |=>
      result[LANE_W-1:0] == (($past(src_a[LANE_W-1:0]) > $past(src_b[LANE_W-1:0]))
                             ? $past(src_a[LANE_W-1:0]) : $past(src_b[LANE_W-1:0])));

  p_keep_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (valid_in && form == 2'b00) |=>
      (result[VEC_W-1:HALF_W] == $past(dst_prev_hi)) && wr_en);

  p_zero_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_in && form == 2'b01) |=> (result[VEC_W-1:HALF_W] == '0) && wr_en);

  p_bad_code_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_in && ev_bad_code) |=> fault && !wr_en && (result == '0));

  p_wide_off_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_in && ev_wide_denied) |=> fault && !wr_en && (result == '0));

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out && !wr_en && !fault);

  p_write_vs_fault_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && fault));

  p_reset_r8: assert property (@(posedge clk)
    rst |=> !valid_out && !wr_en && !fault && (result == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(result));
endmodule

bind pkmax_unit pkmax_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .valid_in       (valid_in),
  .form           (form),
  .wide_en        (wide_en),
  .src_a          (src_a),
  .src_b          (src_b),
  .dst_prev_hi    (dst_prev_hi),
  .valid_out      (valid_out),
  .result         (result),
  .wr_en          (wr_en),
  .fault          (fault),
  .ev_bad_code    (ev_bad_code),
  .ev_wide_denied (ev_wide_denied)
);

// File: tb/sim_pkmax_unit.sv
`timescale 1ns/1ps
module sim_pkmax_unit;
  localparam int LW = 4;
  localparam int NL = 4;
  localparam int VW = LW * NL;
  localparam int HW = VW / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_in = 1'b0;
  logic [1:0]    form = 2'b00;
  logic          wide_en = 1'b0;
  logic [VW-1:0] src_a = '0;
  logic [VW-1:0] src_b = '0;
  logic [HW-1:0] dst_prev_hi = '0;
  logic          valid_out;
  logic [VW-1:0] result;
  logic          wr_en;
  logic          fault;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pkmax_unit #(.LANE_W(LW), .LANES(NL)) u0 (
    .clk(clk), .rst(rst), .valid_in(valid_in), .form(form), .wide_en(wide_en),
    .src_a(src_a), .src_b(src_b), .dst_prev_hi(dst_prev_hi),
    .valid_out(valid_out), .result(result), .wr_en(wr_en), .fault(fault)
  );

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] lane_max_ref(input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] r;
    r = '0;
    for (int k = 0; k < NL; k++) begin
      int av, bv;
      av = int'(a[k*LW +: LW]);
      bv = int'(b[k*LW +: LW]);
      if (bv >= av) r[k*LW +: LW] = b[k*LW +: LW];
      else          r[k*LW +: LW] = a[k*LW +: LW];
    end
    return r;
  endfunction

  task automatic run_vec(input logic [1:0] f, input logic en, input logic [VW-1:0] a,
                         input logic [VW-1:0] b, input logic [HW-1:0] d);
    logic [VW-1:0] m, exp_res;
    logic          exp_fault;
    string         tag;
    m = lane_max_ref(a, b);
    exp_fault = (f == 2'b11) || (f == 2'b10 && !en);
    case (f)
      2'b00:   begin exp_res = {d, m[HW-1:0]};     tag = "R2"; end
      2'b01:   begin exp_res = {{HW{1'b0}}, m[HW-1:0]}; tag = "R3"; end
      2'b10:   begin exp_res = en ? m : '0;        tag = en ? "R4" : "R6"; end
      default: begin exp_res = '0;                 tag = "R5"; end
    endcase
    valid_in = 1'b1; form = f; wide_en = en; src_a = a; src_b = b; dst_prev_hi = d;
    @(negedge clk);
    check("R7 valid_out", {{(VW-1){1'b0}}, valid_out}, {{(VW-1){1'b0}}, 1'b1});
    check({tag, " result"}, result, exp_res);
    check({tag, " fault"}, {{(VW-1){1'b0}}, fault}, {{(VW-1){1'b0}}, exp_fault});
    check({tag, " wr_en"}, {{(VW-1){1'b0}}, wr_en}, {{(VW-1){1'b0}}, !exp_fault});
    if (!exp_fault) check("R1 lower lanes", {{HW{1'b0}}, result[HW-1:0]}, {{HW{1'b0}}, m[HW-1:0]});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a, b, held;
    repeat (2) @(negedge clk);
    check("R8 reset result", result, '0);
    check("R8 reset flags", {{(VW-3){1'b0}}, valid_out, wr_en, fault}, '0);
    rst = 1'b0;

    for (int fi = 0; fi < 4; fi++) begin
      for (int en = 0; en < 2; en++) begin
        for (int x = 0; x < 16; x++) begin
          for (int y = 0; y < 16; y++) begin
            for (int k = 0; k < NL; k++) begin
              a[k*LW +: LW] = 4'((x + 3 * k) % 16);
              b[k*LW +: LW] = 4'((y + 7 * k) % 16);
            end
            run_vec(2'(fi), en[0], a, b, {4'(x) ^ 4'hA, 4'(y)});
          end
        end
      end
    end

    // tie in every lane, all-ones vs zero, top bit 8 against 7
    run_vec(2'b10, 1'b1, 16'h5A3C, 16'h5A3C, 8'h00);
    run_vec(2'b10, 1'b1, 16'hF0F0, 16'h0F0F, 8'h00);
    run_vec(2'b10, 1'b1, 16'h8787, 16'h7878, 8'h00);
    check("R1 unsigned top bit", result, 16'h8888);

    // idle cycle: result held, flags low
    run_vec(2'b00, 1'b0, 16'h1234, 16'h4321, 8'h99);
    held = result;
    valid_in = 1'b0; form = 2'b10; src_a = 16'hFFFF; src_b = 16'hFFFF; dst_prev_hi = 8'h00;
    @(negedge clk);
    check("R9 result held", result, held);
    check("R7 idle flags", {{(VW-3){1'b0}}, valid_out, wr_en, fault}, '0);

    // reset after a faulting operation
    run_vec(2'b11, 1'b1, 16'hFFFF, 16'h0001, 8'h55);
    valid_in = 1'b1; form = 2'b00; rst = 1'b1;
    @(negedge clk);
    check("R8 mid-run reset result", result, '0);
    check("R8 mid-run reset flags", {{(VW-3){1'b0}}, valid_out, wr_en, fault}, '0);
    rst = 1'b0; valid_in = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule